// File: doc/BRIEF.md
# I2C Write-Only Slave Engine with Event Status Codes

This block is the receive side of an I2C-bus slave. It watches SCL and SDA lines that have already been synchronised to the system clock. It finds START, STOP and repeated START conditions and compares the first byte after each START with a programmable 7-bit own address. Optionally it also compares that byte with the General Call address. It accepts only write transfers. Once addressed, it shifts in data bytes MSB first and answers each byte with ACK or NACK on an open-drain SDA output.

Software controls the block through a few register ports: an own-address register, an enable bit, an assert-acknowledge bit and a clear-flag strobe. After each bus event the block raises an interrupt flag and presents an 8-bit status code. While the flag is pending for a byte event, the block holds SCL low, so software sets the pace. All bit timing follows the master's SCL edges, and no bit-rate setting applies.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset the interrupt flag is 0, the status reads 0xF8, and neither SDA nor SCL is driven low.
- R2: With enable=1 and assert-ack=1, an address byte whose bits 7:1 equal own-address bits 7:1 and whose bit 0 (direction) is 0 is ACKed by pulling SDA low during the ninth clock. On the falling edge of that clock the flag is set with status 0x60.
- R3: An address byte whose direction bit is 1, or whose upper seven bits differ from the own address, gets no ACK and sets no flag. The data bytes that follow are ignored until the next START.
- R4: Address byte 0x00 is ACKed with status 0x70 only when own-address bit 0 (General Call enable) is 1. Otherwise it is ignored like a mismatch.
- R5: While enable or assert-ack is 0, the own address and the General Call address are ignored. Once both are 1 again, the next START is matched normally.
- R6: While addressed with assert-ack=1, each data byte is received MSB first and stored in the data output before the flag rises. It is ACKed with status 0x80 after the own address, or 0x90 after a General Call.
- R7: While addressed with assert-ack=0, a data byte is stored and NACKed (SDA left released) with status 0x88 (own) or 0x98 (General Call). The block then stops being addressed, and later bytes are neither ACKed nor flagged.
- R8: While the flag is set with a byte-event status (any code except 0xA0), SCL is held low. A one-cycle pulse on flag_clr clears the flag, sets the status to 0xF8 and releases SCL.
- R9: A STOP or a START seen while addressed sets the flag with status 0xA0, without holding SCL. After a START the block matches the next byte as a new address.
- R10: The ACK decision for a byte is taken in the cycle in which the falling edge of its eighth bit is seen. A control write in that same cycle affects only later bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| addr_we | input | 1 | Write strobe for the own-address register |
| addr_wdata | input | 8 | Own address in bits 7:1, General Call enable in bit 0 |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_en | input | 1 | Enable value written on ctl_we |
| ctl_aa | input | 1 | Assert-acknowledge value written on ctl_we |
| flag_clr | input | 1 | Pulse to clear the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| status | output | 8 | Event status code |
| rx_data | output | 8 | Last received data byte |

## Verification
Two actions can land in the same clock cycle: a software write that clears assert-acknowledge, and the ACK decision taken at the falling SCL edge that ends a data byte. The bench provokes this by issuing the control write on exactly the clock edge where it lowers SCL after the eighth bit. It then requires that byte to be ACKed with the old setting and the following byte to be NACKed with 0x88 or 0x98. Random transfers repeat this collision at random half-periods, mixed with address mismatches, reads, General Calls and aborts.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
   localparam logic [7:0] ST_OWN_W     = 8'h60;
   localparam logic [7:0] ST_GC_W      = 8'h70;
   localparam logic [7:0] ST_OWN_DACK  = 8'h80;
   localparam logic [7:0] ST_OWN_DNACK = 8'h88;
   localparam logic [7:0] ST_GC_DACK   = 8'h90;
   localparam logic [7:0] ST_GC_DNACK  = 8'h98;
   localparam logic [7:0] ST_END       = 8'hA0;
   localparam logic [7:0] ST_IDLE      = 8'hF8;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RECV = 2'd1,
      PH_ACK  = 2'd2
   } phase_t;
endpackage

// File: rtl/i2c_srx_linemon.sv
module i2c_srx_linemon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = ~scl_q & scl_i;
   assign scl_fall  = scl_q & ~scl_i;
   // SDA moving while SCL stays high marks a bus condition
   assign start_det = scl_q & scl_i & sda_q & ~sda_i;
   assign stop_det  = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_srx_shifter.sv
module i2c_srx_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              bit_in,
   output logic [BYTE_W-1:0] byte_q,
   output logic              full
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   logic [CNT_W-1:0] cnt_q;

   assign full = (cnt_q == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         byte_q <= '0;
      end else if (clear) begin
         cnt_q  <= '0;
      end else if (sample && !full) begin
         cnt_q  <= cnt_q + 1'b1;
         byte_q <= {byte_q[BYTE_W-2:0], bit_in};
      end
   end
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs #(
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic [BYTE_W-1:0] addr_wdata,
   input  logic              ctl_we,
   input  logic              ctl_en,
   input  logic              ctl_aa,
   output logic [ADDR_W-1:0] own_addr,
   output logic              gc_en,
   output logic              en,
   output logic              aa
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_addr <= '0;
         en       <= 1'b0;
         aa       <= 1'b0;
      end else begin
         if (addr_we) own_addr <= addr_wdata[BYTE_W-1:1];
         if (ctl_we) begin
            en <= ctl_en;
            aa <= ctl_aa;
         end
      end
   end

   generate
      if (GC_SUPPORT) begin : g_gc
         logic gc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       gc_q <= 1'b0;
            else if (addr_we) gc_q <= addr_wdata[0];
         end
         assign gc_en = gc_q;
      end else begin : g_no_gc
         assign gc_en = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
   import i2c_srx_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              scl_oe,
   input  logic              addr_we,
   input  logic [BYTE_W-1:0] addr_wdata,
   input  logic              ctl_we,
   input  logic              ctl_en,
   input  logic              ctl_aa,
   input  logic              flag_clr,
   output logic              irq_flag,
   output logic [7:0]        status,
   output logic [BYTE_W-1:0] rx_data
);
   generate
      if (ADDR_W != BYTE_W - 1) begin : g_bad_addr_w
         $error("ADDR_W must be BYTE_W-1");
      end
      if (BYTE_W < 2) begin : g_bad_byte_w
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0] own_addr;
   logic gc_en, en_q, aa_q;
   logic [BYTE_W-1:0] rx_byte;
   logic byte_full;

   phase_t phase_q;
   logic   addressed_q;
   logic   gc_mode_q;
   logic   addr_byte_q;
   logic   ack_ok_q;
   logic   ack_drv_q;

   i2c_srx_linemon u_mon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_srx_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .GC_SUPPORT(GC_SUPPORT)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_aa(ctl_aa),
      .own_addr(own_addr), .gc_en(gc_en), .en(en_q), .aa(aa_q)
   );

   logic in_recv, byte_end, ack_end, shift_clr, shift_smp;
   assign in_recv   = (phase_q == PH_RECV);
   assign byte_end  = in_recv & scl_fall & byte_full;
   assign ack_end   = (phase_q == PH_ACK) & scl_fall;
   assign shift_clr = start_det | ack_end;
   assign shift_smp = in_recv & scl_rise;

   i2c_srx_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clear(shift_clr), .sample(shift_smp),
      .bit_in(sda_i), .byte_q(rx_byte), .full(byte_full)
   );

   // address decode on the completed byte
   logic is_gc, may_ack, hit_gc, hit_own;
   assign is_gc   = (rx_byte == '0);
   assign may_ack = en_q & aa_q;
   assign hit_gc  = may_ack & gc_en & is_gc;
   assign hit_own = may_ack & ~is_gc & ~rx_byte[0] & (rx_byte[BYTE_W-1:1] == own_addr);

   logic [7:0] ev_code;
   always_comb begin
      if (addr_byte_q)    ev_code = gc_mode_q ? ST_GC_W : ST_OWN_W;
      else if (gc_mode_q) ev_code = ack_ok_q ? ST_GC_DACK : ST_GC_DNACK;
      else                ev_code = ack_ok_q ? ST_OWN_DACK : ST_OWN_DNACK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         addressed_q <= 1'b0;
         gc_mode_q   <= 1'b0;
         addr_byte_q <= 1'b0;
         ack_ok_q    <= 1'b0;
         ack_drv_q   <= 1'b0;
         irq_flag    <= 1'b0;
         status      <= ST_IDLE;
         rx_data     <= '0;
      end else begin
         if (flag_clr) begin
            irq_flag <= 1'b0;
            status   <= ST_IDLE;
         end
         if (start_det || stop_det) begin
            if (addressed_q) begin
               irq_flag <= 1'b1;
               status   <= ST_END;
            end
            addressed_q <= 1'b0;
            gc_mode_q   <= 1'b0;
            ack_drv_q   <= 1'b0;
            addr_byte_q <= start_det;
            phase_q     <= start_det ? PH_RECV : PH_IDLE;
         end else begin
            unique case (phase_q)
               PH_RECV: begin
                  if (byte_end) begin
                     if (addr_byte_q) begin
                        if (hit_own || hit_gc) begin
                           addressed_q <= 1'b1;
                           gc_mode_q   <= hit_gc;
                           ack_ok_q    <= 1'b1;
                           ack_drv_q   <= 1'b1;
                           phase_q     <= PH_ACK;
                        end else begin
                           phase_q     <= PH_IDLE;
                        end
                     end else begin
                        rx_data   <= rx_byte;
                        ack_ok_q  <= may_ack;
                        ack_drv_q <= may_ack;
                        phase_q   <= PH_ACK;
                     end
                  end
               end
               PH_ACK: begin
                  if (ack_end) begin
                     ack_drv_q   <= 1'b0;
                     irq_flag    <= 1'b1;
                     status      <= ev_code;
                     addr_byte_q <= 1'b0;
                     if (ack_ok_q) begin
                        phase_q <= PH_RECV;
                     end else begin
                        addressed_q <= 1'b0;
                        phase_q     <= PH_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = ack_drv_q;
   assign scl_oe = irq_flag & (status != ST_END);
endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic       scl_oe,
   input logic       flag_clr,
   input logic       irq_flag,
   input logic [7:0] status
);
   assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_flag |-> (status == 8'hF8));

   assert_event_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> (status inside {8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0}));

   assert_ack_on_low_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   assert_nack_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && (status == 8'h88 || status == 8'h98)) |-> !sda_oe);

   assert_stretch_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && status != 8'hA0) |-> scl_oe);

   assert_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag) |-> $past(flag_clr));

   assert_end_unstretched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && status == 8'hA0) |-> !scl_oe);
endmodule

bind i2c_slave_rx i2c_srx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
   .flag_clr(flag_clr), .irq_flag(irq_flag), .status(status)
);

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, scl_oe;
   logic addr_we = 1'b0, ctl_we = 1'b0, ctl_en = 1'b0, ctl_aa = 1'b0, flag_clr = 1'b0;
   logic [7:0] addr_wdata = 8'h00;
   logic irq_flag;
   logic [7:0] status, rx_data;

   wire scl_line = scl_m & ~scl_oe;
   wire sda_line = sda_m & ~sda_oe;

   i2c_slave_rx dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .sda_oe(sda_oe), .scl_oe(scl_oe),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_aa(ctl_aa),
      .flag_clr(flag_clr), .irq_flag(irq_flag), .status(status), .rx_data(rx_data)
   );

   int checks = 0, fails = 0, h = 3, cyc_cnt = 0;
   bit [6:0] m_own = 0;
   bit m_gc = 0, m_en = 0, m_aa = 0, m_addr = 0, m_gcmode = 0;

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt == 180000) begin
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_addr(input bit [6:0] own, input bit gc);
      addr_we = 1'b1; addr_wdata = {own, gc};
      cyc(1); addr_we = 1'b0;
      m_own = own; m_gc = gc;
   endtask

   task automatic wr_ctl(input bit en, input bit aa);
      ctl_we = 1'b1; ctl_en = en; ctl_aa = aa;
      cyc(1); ctl_we = 1'b0;
      m_en = en; m_aa = aa;
   endtask

   task automatic clear_flag;
      if (status != 8'hA0) chk(scl_oe == 1'b1, "R8", "stretch while pending", scl_oe, 1);
      else                 chk(scl_oe == 1'b0, "R9", "no stretch on end code", scl_oe, 0);
      flag_clr = 1'b1; cyc(1); flag_clr = 1'b0; cyc(1);
      chk(irq_flag == 1'b0 && status == 8'hF8 && scl_oe == 1'b0, "R8", "flag clear",
          {irq_flag, scl_oe, status}, 10'h0F8);
   endtask

   task automatic wait_scl_high;
      scl_m = 1'b1;
      cyc(1);
      while (!scl_line) cyc(1);
   endtask

   task automatic expect_end(input string tag);
      if (m_addr) begin
         chk(irq_flag == 1'b1 && status == 8'hA0, "R9", {tag, " end code"}, status, 8'hA0);
         clear_flag();
      end else begin
         chk(irq_flag == 1'b0, "R9", {tag, " no end code when unaddressed"}, irq_flag, 0);
      end
      m_addr = 0;
   endtask

   task automatic do_start;
      sda_m = 1'b1; cyc(h);
      wait_scl_high(); cyc(h);
      sda_m = 1'b0; cyc(h);
      expect_end("start");
      scl_m = 1'b0; cyc(h);
   endtask

   task automatic do_stop;
      sda_m = 1'b0; cyc(h);
      wait_scl_high(); cyc(h);
      sda_m = 1'b1; cyc(h);
      expect_end("stop");
   endtask

   // first: address byte; coll: clear assert-ack on the 8th falling edge (R10)
   task automatic send_byte(input bit [7:0] b, input bit first, input bit coll, input string tag);
      bit exp_flag, exp_ack, was_data, got_ack, is_gc;
      bit [7:0] exp_code;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; cyc(h);
         wait_scl_high(); cyc(h);
         scl_m = 1'b0;
         if (coll && i == 0) begin
            ctl_we = 1'b1; ctl_en = m_en; ctl_aa = 1'b0;
            cyc(1); ctl_we = 1'b0; cyc(h - 1);
         end else begin
            cyc(h);
         end
      end
      was_data = 0; exp_flag = 0; exp_ack = 0; exp_code = 8'hF8;
      if (first) begin
         is_gc = (b == 8'h00);
         exp_ack = m_en & m_aa & (is_gc ? m_gc : (b[7:1] == m_own && !b[0]));
         exp_flag = exp_ack;
         exp_code = is_gc ? 8'h70 : 8'h60;
         if (exp_ack) begin m_addr = 1; m_gcmode = is_gc; end
      end else if (m_addr) begin
         was_data = 1;
         exp_ack = m_en & m_aa;
         exp_flag = 1;
         exp_code = m_gcmode ? (exp_ack ? 8'h90 : 8'h98) : (exp_ack ? 8'h80 : 8'h88);
         if (!exp_ack) m_addr = 0;
      end
      if (coll) m_aa = 0;
      sda_m = 1'b1; cyc(h);
      wait_scl_high(); cyc(h);
      got_ack = !sda_line;
      scl_m = 1'b0; cyc(h);
      chk(got_ack == exp_ack, tag, "ack bit", got_ack, exp_ack);
      chk(irq_flag == exp_flag, tag, "flag", irq_flag, exp_flag);
      if (exp_flag) begin
         chk(status == exp_code, tag, "status", status, exp_code);
         if (was_data) chk(rx_data == b, tag, "data byte", rx_data, b);
         clear_flag();
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      cyc(3);
      // R1 reset state
      chk(irq_flag == 0 && status == 8'hF8 && !sda_oe && !scl_oe, "R1", "reset state",
          {irq_flag, sda_oe, scl_oe, status}, 11'h0F8);
      rst_n = 1'b1; cyc(2);
      chk(irq_flag == 0 && status == 8'hF8 && !sda_oe && !scl_oe, "R1", "after reset",
          {irq_flag, sda_oe, scl_oe, status}, 11'h0F8);

      // R2, R6, R9: own address write, data, stop
      wr_addr(7'h3A, 1'b0); wr_ctl(1'b1, 1'b1);
      do_start(); send_byte(8'h74, 1, 0, "R2"); send_byte(8'hA5, 0, 0, "R6");
      send_byte(8'h5A, 0, 0, "R6"); do_stop();

      // R3: read direction, then mismatching address
      do_start(); send_byte(8'h75, 1, 0, "R3"); send_byte(8'hFF, 0, 0, "R3");
      do_start(); send_byte(8'h12, 1, 0, "R3"); send_byte(8'h00, 0, 0, "R3"); do_stop();

      // R4: general call disabled then enabled; R10 and R7 collision
      do_start(); send_byte(8'h00, 1, 0, "R4"); do_stop();
      wr_addr(7'h3A, 1'b1);
      do_start(); send_byte(8'h00, 1, 0, "R4"); send_byte(8'h3C, 0, 0, "R6");
      send_byte(8'hC3, 0, 1, "R10"); send_byte(8'h99, 0, 0, "R7");
      send_byte(8'h66, 0, 0, "R7"); do_stop();

      // R5: assert-ack low, then restored; R9 repeated start while addressed
      do_start(); send_byte(8'h74, 1, 0, "R5"); do_stop();
      wr_ctl(1'b0, 1'b1);
      do_start(); send_byte(8'h74, 1, 0, "R5"); do_stop();
      wr_ctl(1'b1, 1'b1);
      do_start(); send_byte(8'h74, 1, 0, "R5"); send_byte(8'h81, 0, 0, "R6");
      do_start(); send_byte(8'h74, 1, 0, "R9"); send_byte(8'h18, 0, 1, "R10");
      send_byte(8'h24, 0, 0, "R7"); do_stop();

      // constrained random transfers
      wr_ctl(1'b1, 1'b1);
      for (int t = 0; t < 40; t++) begin
         int kind, nb;
         bit [7:0] ab;
         h = 2 + int'($urandom % 5);
         if ($urandom % 4 == 0) wr_addr(7'(1 + $urandom % 127), 1'($urandom % 2));
         wr_ctl(($urandom % 10) != 0, ($urandom % 5) != 0);
         kind = int'($urandom % 4);
         case (kind)
            0: ab = {m_own, 1'b0};
            1: ab = {m_own, 1'b1};
            2: ab = 8'h00;
            default: ab = 8'($urandom);
         endcase
         do_start();
         send_byte(ab, 1, 0, "R2");
         nb = int'($urandom % 5);
         for (int k = 0; k < nb; k++) begin
            if ($urandom % 6 == 0) wr_ctl(m_en, 1'b1);
            send_byte(8'($urandom), 0, ($urandom % 7) == 0, "R10");
         end
         if ($urandom % 2 == 0) do_stop();
      end
      do_stop();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule